// File: doc/BRIEF.md
# Dual-Mode Compare PWM Generator

The block drives one PWM pin from a 16-bit counter that advances once per prescaled tick. In edge-aligned mode the counter wraps after reaching the block's own period register. The pin is high from count zero until the count reaches compare register A. In center-aligned mode an external synchronizing timer supplies the wrap value. The pin is then set when the count equals compare A and cleared when it equals compare B.

Software writes a buffer copy of the period and of both compare registers at any time. All three buffers are copied into the active set in the same clock as a counter wrap, so a period that is already running keeps its timing. The prescaler divides the counting clock by a power of two, down to 1:1.

Top module: `pwm_dual_gen`

## Requirements
- R1: In edge-aligned mode (mode_i = 0) the output repeats every (P + 1) × D clock cycles, where P is the active period value and D is the prescale ratio.
- R2: In edge-aligned mode the output is high while the count is below the active compare A value, so it is high for A × D clock cycles per period when A ≤ P. The output is registered and lags the count by one clock.
- R3: In edge-aligned mode an active compare A of zero keeps the output low, and this includes a period of zero.
- R4: In edge-aligned mode a compare A value greater than the period value keeps the output high for every cycle.
- R5: In center-aligned mode (mode_i = 1) the counter wraps at sync_per_i, or at any count at or above it, and the period is (sync_per_i + 1) × D clock cycles.
- R6: In center-aligned mode the output is cleared in the cycle after the count equals compare B, and set in the cycle after it equals compare A. The clear wins when both match, so all-zero settings keep the output low.
- R7: In center-aligned mode a compare B value above sync_per_i is never reached, and once set the output stays high.
- R8: Writes go to buffer registers at address 0 (period), 1 (compare A) or 2 (compare B). The buffers are copied to the active registers only in a clock where the counter wraps. A write during a period does not change that period's length or high time.
- R9: presc_sel_i = s gives a prescale ratio D = 2^s, so s = 0 is 1:1. The counter holds its value between ticks.
- R10: While rst_ni is low, the counter, the prescaler, all buffer and active registers and the output are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 period, 1 compare A, 2 compare B |
| wr_data_i | input | 16 | Write data |
| presc_sel_i | input | 2 | Prescale exponent, ratio 2^value |
| mode_i | input | 1 | 0 edge-aligned, 1 center-aligned |
| sync_per_i | input | 16 | Period value from the synchronizing timer |
| pwm_o | output | 1 | PWM output pin |

## Verification
A buffer write and the shadow copy can fall in the same clock when a write lands on a counter wrap. The bench provokes this with a zero period at 1:1 prescale, where every clock wraps, and with writes placed a few clocks into a running period. A behavioural reference model is compared every clock. It applies a write made on the wrap edge one period later. A write inside a period is judged by measuring that period's length and high time, then those of the next period.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  typedef enum logic {MODE_EDGE = 1'b0, MODE_CENTER = 1'b1} pwm_mode_e;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADDR_PER  = 2'd0;
  localparam logic [AW-1:0] ADDR_CMPA = 2'd1;
  localparam logic [AW-1:0] ADDR_CMPB = 2'd2;
endpackage

// File: rtl/pwm_dual_presc.sv
module pwm_dual_presc #(
  parameter int unsigned PSW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PSW-1:0] sel_i,
  output logic           tick_o
);
  localparam int unsigned PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pc_q, lim;

  assign lim    = ~({PCW{1'b1}} << sel_i);
  assign tick_o = (pc_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dual_cnt.sv
module pwm_dual_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cur_per_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  assign wrap_o = tick_i && (cnt_o >= cur_per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_o <= $past(cur_per_i)));
  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          load_i,
  output logic [W-1:0]  act_per_o,
  output logic [W-1:0]  act_a_o,
  output logic [W-1:0]  act_b_o
);
  typedef struct packed {
    logic [W-1:0] per;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } cfg_t;

  cfg_t buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PER:  buf_q.per <= wr_data_i;
        ADDR_CMPA: buf_q.a   <= wr_data_i;
        ADDR_CMPB: buf_q.b   <= wr_data_i;
        default: ;
      endcase
    end
  end

  // shadow copy only at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= buf_q;
  end

  assign act_per_o = act_q.per;
  assign act_a_o   = act_q.a;
  assign act_b_o   = act_q.b;

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/pwm_dual_out.sv
module pwm_dual_out
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  pwm_mode_e    mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] act_per_i,
  input  logic [W-1:0] act_a_i,
  input  logic [W-1:0] act_b_i,
  output logic         pwm_o
);
  logic pwm_d;

  always_comb begin
    pwm_d = pwm_o;
    if (mode_i == MODE_EDGE) begin
      pwm_d = (cnt_i < act_a_i);
    end else begin
      if (cnt_i == act_b_i)      pwm_d = 1'b0;
      else if (cnt_i == act_a_i) pwm_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= pwm_d;
  end

  p_zero_duty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && act_a_i == '0) |=> !pwm_o);
  p_full_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && act_a_i > act_per_i && cnt_i <= act_per_i) |=> pwm_o);
  p_center_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CENTER && cnt_i == act_b_i) |=> !pwm_o);
  p_center_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CENTER && cnt_i == act_a_i && cnt_i != act_b_i) |=> pwm_o);
endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_dual_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned PSW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [PSW-1:0] presc_sel_i,
  input  logic           mode_i,
  input  logic [W-1:0]   sync_per_i,
  output logic           pwm_o
);
  pwm_mode_e    mode;
  logic         tick, wrap;
  logic [W-1:0] cnt, cur_per, act_per, act_a, act_b;

  assign mode    = pwm_mode_e'(mode_i);
  assign cur_per = (mode == MODE_CENTER) ? sync_per_i : act_per;

  pwm_dual_presc #(.PSW(PSW)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (presc_sel_i),
    .tick_o(tick)
  );

  pwm_dual_cnt #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cur_per_i(cur_per),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  pwm_dual_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .load_i   (wrap),
    .act_per_o(act_per),
    .act_a_o  (act_a),
    .act_b_o  (act_b)
  );

  pwm_dual_out #(.W(W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .cnt_i    (cnt),
    .act_per_i(act_per),
    .act_a_i  (act_a),
    .act_b_i  (act_b),
    .pwm_o    (pwm_o)
  );
endmodule

// File: tb/pwm_dual_gen_bench.sv
module pwm_dual_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  presc_sel_i = '0;
  logic        mode_i = 1'b0;
  logic [15:0] sync_per_i = '0;
  logic        pwm_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  pwm_dual_gen u_pwm_dual_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .presc_sel_i(presc_sel_i),
    .mode_i     (mode_i),
    .sync_per_i (sync_per_i),
    .pwm_o      (pwm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_pc, m_cnt, m_per, m_a, m_b, b_per, b_a, b_b;
  bit m_q;

  always @(posedge clk_i or negedge rst_ni) begin
    int lim, cur;
    bit tick, wrap, nq;
    if (!rst_ni) begin
      m_pc <= 0; m_cnt <= 0; m_per <= 0; m_a <= 0; m_b <= 0;
      b_per <= 0; b_a <= 0; b_b <= 0; m_q <= 0;
    end else begin
      lim  = (1 << presc_sel_i) - 1;
      tick = (m_pc >= lim);
      cur  = mode_i ? int'(sync_per_i) : m_per;
      wrap = tick && (m_cnt >= cur);
      if (!mode_i)           nq = (m_cnt < m_a);
      else if (m_cnt == m_b) nq = 0;
      else if (m_cnt == m_a) nq = 1;
      else                   nq = m_q;
      m_q  <= nq;
      m_pc <= tick ? 0 : m_pc + 1;
      if (wrap)      m_cnt <= 0;
      else if (tick) m_cnt <= m_cnt + 1;
      if (wrap) begin m_per <= b_per; m_a <= b_a; m_b <= b_b; end
      if (wr_en_i) begin
        if (wr_addr_i == 2'd0) b_per <= int'(wr_data_i);
        if (wr_addr_i == 2'd1) b_a   <= int'(wr_data_i);
        if (wr_addr_i == 2'd2) b_b   <= int'(wr_data_i);
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) chk(pwm_o == m_q, "R8 model", int'(pwm_o), int'(m_q));
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic window(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      hi += int'(pwm_o);
    end
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    ok = 0;
    prev = pwm_o;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!prev && pwm_o) begin ok = 1; break; end
      prev = pwm_o;
    end
  endtask

  // called right after a rise; counts until the next rise
  task automatic period_after_rise(input bit do_write, output int len, output int hi);
    bit prev;
    len = 1; hi = 1; prev = 1;
    for (int i = 1; i < 2000; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
      if (do_write && i == 3) begin wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'd15; end
      if (do_write && i == 4) begin wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'd29; end
      if (!prev && pwm_o) break;
      len++;
      hi += int'(pwm_o);
      prev = pwm_o;
    end
    wr_en_i = 1'b0;
  endtask

  task automatic measure(input string req, input int exp_len, input int exp_hi);
    bit ok;
    int len, hi;
    wait_rise(ok);
    chk(ok, req, int'(ok), 1);
    period_after_rise(1'b0, len, hi);
    chk(len == exp_len, req, len, exp_len);
    chk(hi == exp_hi, req, hi, exp_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, len;
    bit ok;
    repeat (5) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R10 reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    settle(8);
    chk(pwm_o == 1'b0, "R10 after reset", int'(pwm_o), 0);

    // R1 R2: edge mode, period 9, duty 3, 1:1
    wr(2'd0, 9); wr(2'd1, 3);
    settle(60);
    measure("R1 R2 edge", 10, 3);

    // R9: prescale 1:4
    presc_sel_i = 2'd2;
    settle(100);
    measure("R9 presc", 40, 12);
    presc_sel_i = 2'd0;

    // R3: zero duty and zero period
    wr(2'd1, 0); wr(2'd0, 0);
    settle(40);
    window(64, hi);
    chk(hi == 0, "R3 zero", hi, 0);

    // R4: duty above period
    wr(2'd0, 9); wr(2'd1, 20);
    settle(40);
    window(64, hi);
    chk(hi == 64, "R4 full", hi, 64);

    // R8: mid-period write leaves current period intact
    wr(2'd0, 19); wr(2'd1, 5);
    settle(60);
    wait_rise(ok);
    chk(ok, "R8 rise", int'(ok), 1);
    period_after_rise(1'b1, len, hi);
    chk(len == 20, "R8 current len", len, 20);
    chk(hi == 5, "R8 current hi", hi, 5);
    len = 1; hi = 1;
    period_after_rise(1'b0, len, hi);
    chk(len == 30, "R8 next len", len, 30);
    chk(hi == 15, "R8 next hi", hi, 15);

    // R5 R6: center mode
    mode_i = 1'b1; sync_per_i = 16'd19;
    wr(2'd1, 5); wr(2'd2, 12);
    settle(80);
    measure("R5 R6 center", 20, 7);

    // R6: all zero keeps low
    sync_per_i = 16'd0;
    wr(2'd1, 0); wr(2'd2, 0);
    settle(40);
    window(64, hi);
    chk(hi == 0, "R6 zero", hi, 0);

    // R7: fall beyond sync period
    sync_per_i = 16'd19;
    wr(2'd1, 5); wr(2'd2, 25);
    settle(80);
    window(64, hi);
    chk(hi == 64, "R7 full", hi, 64);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule